// File: doc/BRIEF.md
# Serial Bus Command Framer

This block turns one command request into a framed bit stream on a two-wire serial link where the master owns both the clock and the data line. A request carries a target ID, a command type, an address, a transfer size and write data. The block assembles the message bits for that command, runs a serial 4-bit CRC over an implicit leading start bit and the message, and shifts start bit, message and CRC out one bit per link clock period.

The transfer size is not sent as a byte count. It is folded into the low address bits plus one size flag. Write payload bytes follow the size flag, lowest byte first. The data line carries the complement of each logical bit. It changes only in the low half of the link clock, so a receiver can sample on the rising edge. A one-cycle `done` pulse marks the end of a frame. Requests that arrive while a frame is in flight are dropped.

Top module: `sbf_framer`

## Requirements
- R1: After reset and whenever idle, `link_clk` and `link_data` are 1 and `busy` and `done` are 0.
- R2: Each frame is a start bit of logical 1, then the message bits most significant first, then the 4 CRC bits. `link_data` carries the inverse of each logical bit. Each bit spans one link period of 2*HALF_CYC cycles, low half first, and `link_data` changes only while `link_clk` is low.
- R3: `cmd` code 0 (read) and code 1 (write) send a 28-bit header: 2-bit ID, opcode 100, an access bit (1 = read, 0 = write), 21 address bits and a size flag.
- R4: `size` code 0 means 1 byte (flag 0, address unchanged). Code 1 means 2 bytes (flag 1, address bit 0 sent as 0). Codes 2 and 3 mean 4 bytes (flag 1, address bits 1:0 sent as 01).
- R5: A write appends exactly the selected number of payload bytes after the size flag. `wdata[7:0]` goes first, then `wdata[15:8]`, and so on, each byte most significant bit first. A read appends none.
- R6: `cmd` code 2 (data poll) sends the 2-bit ID followed by 010, and nothing else before the CRC.
- R7: `cmd` code 3 (terminate) sends the 2-bit ID followed by six 1 bits, and nothing else before the CRC.
- R8: The CRC register starts at 0. For every bit b of the start bit and message, it is updated as f = c[3]^b, c = {c[2], c[1], c[0]^f, f}, which is the polynomial x^4+x+1. It is sent c[3] first.
- R9: `busy` is 1 from the cycle after a request is accepted. `done` is high for exactly one cycle, which is the cycle in which `busy` returns to 0.
- R10: A request while `busy` is 1 has no effect on the frame in progress and starts no further frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, accepted when idle |
| tgt_id | input | 2 | Target ID |
| cmd | input | 2 | 0 read, 1 write, 2 data poll, 3 terminate |
| addr | input | 21 | Byte address for read and write |
| size | input | 2 | 0: 1 byte, 1: 2 bytes, 2/3: 4 bytes |
| wdata | input | 32 | Write payload, byte 0 in bits 7:0 |
| busy | output | 1 | Frame in flight |
| done | output | 1 | One-cycle pulse at frame end |
| link_clk | output | 1 | Serial link clock, idles high |
| link_data | output | 1 | Serial data, inverted polarity, idles high |

## Verification
A corrupted shift register or bit counter shows up on the wire within the same frame. The decoded bit string from one rising edge of `link_clk` to the next has the wrong length or content, so a read, a write, a poll and a terminate frame compared bit by bit expose field order, size folding and byte order. A CRC state error has no visible effect until the last four bit periods, so every frame is checked to its final CRC bit. A phase or divider error shows up as a link period other than four cycles, or as data moving during the high half. A leaked request shows up as a changed frame or as a second burst of link clocks after `done`.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
  typedef enum logic [1:0] {
    CMD_READ  = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_POLL  = 2'd2,
    CMD_TERM  = 2'd3
  } sbf_cmd_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_MSG   = 2'd2,
    PH_CRC   = 2'd3
  } sbf_phase_e;

  localparam logic [2:0] OP_ADDR = 3'b100;
  localparam logic [2:0] OP_POLL = 3'b010;
  localparam logic [5:0] OP_TERM = 6'h3F;
  localparam int         CRC_W   = 4;
endpackage

// File: rtl/sbf_half_timer.sv
module sbf_half_timer #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  assert_half_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/sbf_crc4.sv
module sbf_crc4 (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       feed,
  input  logic       din,
  output logic [3:0] crc_q,
  output logic [3:0] crc_fed
);
  logic fb;

  assign fb      = crc_q[3] ^ din;
  assign crc_fed = {crc_q[2], crc_q[1], crc_q[0] ^ fb, fb};

  always_ff @(posedge clk) begin
    if (rst || clear) crc_q <= '0;
    else if (feed)    crc_q <= crc_fed;
  end

  assert_clear_feed_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(clear && feed));
endmodule

// File: rtl/sbf_frame_build.sv
module sbf_frame_build
  import sbf_pkg::*;
#(
  parameter int ID_W       = 2,
  parameter int ADDR_W     = 21,
  parameter int DATA_BYTES = 4,
  parameter int MSG_W      = ID_W + 5 + ADDR_W + 8 * DATA_BYTES,
  parameter int LEN_W      = $clog2(MSG_W + 1)
) (
  input  logic [ID_W-1:0]         id,
  input  logic [1:0]              cmd,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [1:0]              size,
  input  logic [8*DATA_BYTES-1:0] wdata,
  output logic [MSG_W-1:0]        frame,
  output logic [LEN_W-1:0]        len
);
  localparam int HDR_W = ID_W + 5 + ADDR_W;
  localparam int DW    = 8 * DATA_BYTES;

  logic [ADDR_W-1:0] a_fold;
  logic              size_flag;
  logic [LEN_W-1:0]  nbytes;
  logic [DW-1:0]     dswap;
  logic [HDR_W-1:0]  hdr;

  always_comb begin
    a_fold    = addr;
    size_flag = (size != 2'd0);
    nbytes    = LEN_W'(1);
    if (size == 2'd1) begin
      a_fold[0] = 1'b0;
      nbytes    = LEN_W'(2);
    end else if (size[1]) begin
      a_fold[1:0] = 2'b01;
      nbytes      = LEN_W'(4);
    end
    for (int i = 0; i < DATA_BYTES; i++)
      dswap[(DATA_BYTES-1-i)*8 +: 8] = wdata[i*8 +: 8];
    hdr = {id, OP_ADDR, (cmd == CMD_READ), a_fold, size_flag};
  end

  always_comb begin
    frame = '0;
    len   = '0;
    case (cmd)
      CMD_READ: begin
        frame = {hdr, {DW{1'b0}}};
        len   = LEN_W'(HDR_W);
      end
      CMD_WRITE: begin
        frame = {hdr, dswap};
        len   = LEN_W'(HDR_W) + (nbytes << 3);
      end
      CMD_POLL: begin
        frame = {id, OP_POLL, {(MSG_W-ID_W-3){1'b0}}};
        len   = LEN_W'(ID_W + 3);
      end
      default: begin
        frame = {id, OP_TERM, {(MSG_W-ID_W-6){1'b0}}};
        len   = LEN_W'(ID_W + 6);
      end
    endcase
  end
endmodule

// File: rtl/sbf_framer.sv
module sbf_framer
  import sbf_pkg::*;
#(
  parameter int ID_W       = 2,
  parameter int ADDR_W     = 21,
  parameter int DATA_BYTES = 4,
  parameter int HALF_CYC   = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req,
  input  logic [ID_W-1:0]         tgt_id,
  input  logic [1:0]              cmd,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [1:0]              size,
  input  logic [8*DATA_BYTES-1:0] wdata,
  output logic                    busy,
  output logic                    done,
  output logic                    link_clk,
  output logic                    link_data
);
  localparam int MSG_W = ID_W + 5 + ADDR_W + 8 * DATA_BYTES;
  localparam int LEN_W = $clog2(MSG_W + 1);

  sbf_phase_e       phase;
  logic [MSG_W-1:0] sr;
  logic [LEN_W-1:0] left;
  logic [2:0]       crc_sent;
  logic             cur_bit;
  logic [MSG_W-1:0] bld_frame;
  logic [LEN_W-1:0] bld_len;
  logic             tick;
  logic             period_end;
  logic             crc_clear;
  logic             crc_feed;
  logic [3:0]       crc_q;
  logic [3:0]       crc_fed;
  logic             crc_pick;
  logic             accept;

  sbf_frame_build #(
    .ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES),
    .MSG_W(MSG_W), .LEN_W(LEN_W)
  ) u_build (
    .id(tgt_id), .cmd(cmd), .addr(addr), .size(size), .wdata(wdata),
    .frame(bld_frame), .len(bld_len)
  );

  sbf_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk(clk), .rst(rst), .run(busy), .tick(tick)
  );

  assign accept     = (phase == PH_IDLE) && req;
  assign period_end = tick && link_clk;
  assign crc_clear  = accept;
  assign crc_feed   = period_end && (phase == PH_START || phase == PH_MSG);
  assign crc_pick   = crc_q[2'd3 - crc_sent[1:0]];

  sbf_crc4 u_crc (
    .clk(clk), .rst(rst), .clear(crc_clear), .feed(crc_feed), .din(cur_bit),
    .crc_q(crc_q), .crc_fed(crc_fed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      busy      <= 1'b0;
      done      <= 1'b0;
      link_clk  <= 1'b1;
      link_data <= 1'b1;
      cur_bit   <= 1'b0;
      sr        <= '0;
      left      <= '0;
      crc_sent  <= '0;
    end else begin
      done <= 1'b0;
      if (phase == PH_IDLE) begin
        if (req) begin
          phase     <= PH_START;
          busy      <= 1'b1;
          link_clk  <= 1'b0;
          link_data <= 1'b0;
          cur_bit   <= 1'b1;
          sr        <= bld_frame;
          left      <= bld_len;
        end
      end else if (tick) begin
        if (!link_clk) begin
          link_clk <= 1'b1;
        end else if (phase != PH_CRC && left != '0) begin
          phase     <= PH_MSG;
          cur_bit   <= sr[MSG_W-1];
          link_data <= ~sr[MSG_W-1];
          sr        <= sr << 1;
          left      <= left - 1'b1;
          link_clk  <= 1'b0;
        end else if (phase != PH_CRC) begin
          phase     <= PH_CRC;
          crc_sent  <= 3'd1;
          cur_bit   <= crc_fed[3];
          link_data <= ~crc_fed[3];
          link_clk  <= 1'b0;
        end else if (crc_sent != 3'(CRC_W)) begin
          crc_sent  <= crc_sent + 1'b1;
          cur_bit   <= crc_pick;
          link_data <= ~crc_pick;
          link_clk  <= 1'b0;
        end else begin
          phase     <= PH_IDLE;
          busy      <= 1'b0;
          done      <= 1'b1;
          link_data <= 1'b1;
        end
      end
    end
  end

  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (link_clk && link_data));

  assert_data_moves_low_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$stable(link_data)) |-> !link_clk);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_ends_busy_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  assert_req_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && req && phase != PH_START) |=> phase != PH_START);

  assert_crc_count_R8: assert property (@(posedge clk) disable iff (rst)
    crc_sent <= 3'(CRC_W));
endmodule

// File: tb/tb_sbf_framer.sv
module tb_sbf_framer;
  logic        clk = 1'b0;
  logic        rst;
  logic        req;
  logic [1:0]  tgt_id;
  logic [1:0]  cmd;
  logic [20:0] addr;
  logic [1:0]  size;
  logic [31:0] wdata;
  logic        busy, done, link_clk, link_data;

  int checks = 0;
  int errors = 0;

  logic exp_b [0:127];
  int   exp_n;
  logic got_b [0:127];
  int   got_n;

  always #5 clk = ~clk;

  sbf_framer dut (
    .clk(clk), .rst(rst), .req(req), .tgt_id(tgt_id), .cmd(cmd),
    .addr(addr), .size(size), .wdata(wdata), .busy(busy), .done(done),
    .link_clk(link_clk), .link_data(link_data)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic push(input logic [63:0] v, input int w);
    for (int i = w - 1; i >= 0; i--) begin
      exp_b[exp_n] = v[i];
      exp_n++;
    end
  endtask

  task automatic build_exp(input logic [1:0] i_id, input logic [1:0] i_cmd,
                           input logic [20:0] i_addr, input logic [1:0] i_size,
                           input logic [31:0] i_wd);
    logic [20:0] a;
    logic [3:0]  c;
    logic        f;
    int          nb;
    exp_n = 0;
    push(64'(i_id), 2);
    if (i_cmd == 2'd2) push(64'b010, 3);                // R6
    else if (i_cmd == 2'd3) push(64'h3F, 6);            // R7
    else begin                                          // R3, R4, R5
      a  = i_addr;
      nb = 1;
      if (i_size == 2'd1) begin a[0] = 1'b0; nb = 2; end
      else if (i_size[1]) begin a[1:0] = 2'b01; nb = 4; end
      push(64'b100, 3);
      push(64'(i_cmd == 2'd0), 1);
      push(64'(a), 21);
      push(64'(i_size != 2'd0), 1);
      if (i_cmd == 2'd1)
        for (int k = 0; k < nb; k++) push(64'(i_wd[k*8 +: 8]), 8);
    end
    c = 4'd0;                                           // R8
    f = c[3] ^ 1'b1;
    c = {c[2], c[1], c[0] ^ f, f};
    for (int k = 0; k < exp_n; k++) begin
      f = c[3] ^ exp_b[k];
      c = {c[2], c[1], c[0] ^ f, f};
    end
    push(64'(c), 4);
  endtask

  // Drives one request, decodes the wire, compares against the expected frame.
  task automatic run_frame(input string tag, input logic [1:0] i_id,
                           input logic [1:0] i_cmd, input logic [20:0] i_addr,
                           input logic [1:0] i_size, input logic [31:0] i_wd,
                           input bit inject);
    logic prev_clk;
    int   cyc, last_rise, bad_period, bad_move, first_bad, ndone, t;
    logic prev_data;
    build_exp(i_id, i_cmd, i_addr, i_size, i_wd);
    @(negedge clk);
    tgt_id = i_id; cmd = i_cmd; addr = i_addr; size = i_size; wdata = i_wd;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk(busy === 1'b1, "R9", {tag, " busy after accept"}, 64'(busy), 1);
    got_n = 0; cyc = 0; last_rise = -1; bad_period = 0; bad_move = 0;
    prev_clk = link_clk; prev_data = link_data; ndone = 0; t = 0;
    while (ndone == 0 && t < 3000) begin
      @(negedge clk);
      cyc++; t++;
      if (inject && cyc == 30) begin
        tgt_id = ~i_id; cmd = 2'd3; req = 1'b1;
      end else if (inject && cyc == 31) req = 1'b0;
      if (!prev_clk && link_clk) begin
        if (got_n < 128) got_b[got_n] = ~link_data;
        got_n++;
        if (last_rise >= 0 && cyc - last_rise != 4) bad_period++;
        last_rise = cyc;
      end
      if (busy && prev_clk && link_clk && link_data !== prev_data) bad_move++;
      if (done) ndone++;
      prev_clk = link_clk; prev_data = link_data;
    end
    chk(ndone == 1, "R9", {tag, " done seen"}, ndone, 1);
    chk(busy === 1'b0, "R9", {tag, " busy low with done"}, 64'(busy), 0);
    @(negedge clk);
    chk(done === 1'b0, "R9", {tag, " done one cycle"}, 64'(done), 0);
    chk(got_n == exp_n + 1, "R2", {tag, " wire bit count"}, got_n, exp_n + 1);
    chk(got_b[0] === 1'b1, "R2", {tag, " start bit"}, 64'(got_b[0]), 1);
    first_bad = -1;
    for (int k = 0; k < exp_n && k + 1 < got_n && k < 127; k++)
      if (first_bad < 0 && got_b[k+1] !== exp_b[k]) first_bad = k;
    chk(first_bad < 0, "R2/R3/R8", {tag, " frame bits (first bad index)"},
        first_bad, -1);
    chk(bad_period == 0 && bad_move == 0, "R2", {tag, " link timing errors"},
        bad_period + bad_move, 0);
    chk(link_clk === 1'b1 && link_data === 1'b1, "R1", {tag, " idle lines"},
        64'({link_clk, link_data}), 3);
    ndone = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (busy || !link_clk) ndone++;
    end
    chk(ndone == 0, "R10", {tag, " no further frame"}, ndone, 0);
  endtask

  task automatic t_reset;
    chk(link_clk === 1'b1 && link_data === 1'b1 && busy === 1'b0 && done === 1'b0,
        "R1", "reset outputs", 64'({link_clk, link_data, busy, done}), 64'b1100);
  endtask

  task automatic t_read;
    run_frame("R3 read 1B", 2'd1, 2'd0, 21'h1ABCDF, 2'd0, 32'hFFFF_FFFF, 1'b0);
    run_frame("R4 read 2B", 2'd2, 2'd0, 21'h0F0F0F, 2'd1, 32'h0, 1'b0);
    run_frame("R4 read 4B", 2'd3, 2'd0, 21'h155552, 2'd2, 32'h0, 1'b0);
  endtask

  task automatic t_write;
    run_frame("R5 write 1B", 2'd0, 2'd1, 21'h000123, 2'd0, 32'hDEAD_BEA5, 1'b0);
    run_frame("R5 write 2B", 2'd1, 2'd1, 21'h1FFFFF, 2'd1, 32'h1234_C35A, 1'b0);
    run_frame("R5 write 4B", 2'd2, 2'd1, 21'h0AAAAA, 2'd3, 32'h8142_7E18, 1'b0);
  endtask

  task automatic t_poll;
    run_frame("R6 poll", 2'd2, 2'd2, 21'h1FFFFF, 2'd3, 32'hFFFF_FFFF, 1'b0);
  endtask

  task automatic t_term;
    run_frame("R7 term", 2'd1, 2'd3, 21'h1FFFFF, 2'd2, 32'hFFFF_FFFF, 1'b0);
  endtask

  task automatic t_ignore;
    run_frame("R10 busy req", 2'd0, 2'd1, 21'h03C3C3, 2'd2, 32'hCAFE_F00D, 1'b1);
  endtask

  initial begin
    rst = 1'b1; req = 1'b0; tgt_id = '0; cmd = '0; addr = '0; size = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read();
    t_write();
    t_poll();
    t_term();
    t_ignore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule